// File: doc/BRIEF.md
# Dynamic Loss-Scale Controller

This block keeps the power-of-two factor that multiplies the training loss, so that small gradients stay inside the range of a narrow floating-point format. The factor is held as a signed exponent. Scaling and unscaling then only add to or subtract from the exponent field of each value. Overflow detection happens elsewhere. Once per training iteration that logic pulses an iteration strobe together with one flag, which is set when any gradient of the iteration came out infinite or NaN.

When the flag is set, the controller lowers the exponent by one, which halves the scale. It also raises a skip indication so that the weight-update logic drops that iteration. When iterations stay clean for a programmable number in a row, the controller raises the exponent by one, which doubles the scale. The exponent never leaves a programmable window.

The exponent and the clean-run count are always visible on output ports, so a checkpoint can save them. A restore port writes both back, so a resumed run continues from the saved scale and does not fall back to the large starting value.

Top module: `loss_scale_ctrl`

## Requirements
- R1: After reset the exponent equals the parameter INIT_EXP (default 15), the clean count is 0, and skip and done are low.
- R2: A strobe with the overflow flag set lowers the exponent by one when it is above the minimum, clears the clean count and raises skip.
- R3: A strobe with the overflow flag clear, when the clean count plus one reaches the interval, raises the exponent by one when it is below the maximum and clears the clean count.
- R4: A strobe with the overflow flag clear, when the clean count plus one is below the interval, increments the clean count and leaves the exponent unchanged.
- R5: An overflow strobe with the exponent at or below the minimum leaves the exponent unchanged but still raises skip and clears the count.
- R6: An increase due with the exponent at or above the maximum leaves the exponent unchanged and still clears the clean count.
- R7: The restore input loads the exponent and clean count from the restore ports on the next cycle. It wins over a strobe in the same cycle, and that strobe then produces no done and no skip.
- R8: done and skip appear exactly one cycle after an accepted strobe, for one cycle. done is low in every other cycle, and skip is never high without done.
- R9: The exponent and clean count outputs show the current state in every cycle, in two's complement and unsigned binary respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iter_valid_i | input | 1 | One-cycle strobe at the end of each iteration |
| grad_overflow_i | input | 1 | The iteration produced an infinite or NaN gradient |
| cfg_interval_i | input | CNT_W | Clean iterations needed before an increase |
| cfg_min_exp_i | input | EXP_W | Lowest exponent, signed |
| cfg_max_exp_i | input | EXP_W | Highest exponent, signed |
| restore_i | input | 1 | Load saved state |
| restore_exp_i | input | EXP_W | Saved exponent, signed |
| restore_cnt_i | input | CNT_W | Saved clean count |
| scale_exp_o | output | EXP_W | Current exponent, signed |
| clean_cnt_o | output | CNT_W | Current clean-run count |
| skip_o | output | 1 | Discard this iteration's update |
| done_o | output | 1 | Result of the last strobe is valid |

## Verification
The hardest states to reach are the increase at the full default interval of 2000 and the saturated edges. Walking there with clean strobes takes thousands of cycles and depends on every earlier count being right. The bench reaches them through the restore port: it loads a count just short of the interval with an exponent near a bound, and then issues the last few strobes. A restore that lands in the same cycle as a strobe is driven on purpose to show that the restore has priority. A long random mix of strobes, overflow flags, idle gaps and restores inside a narrow exponent window then exercises the saturated edges again and again.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_OVF   = 2'd2,
    CMD_CLEAN = 2'd3
  } lsc_cmd_e;
endpackage

// File: rtl/lsc_clean_cnt.sv
module lsc_clean_cnt
  import lsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lsc_cmd_e         cmd_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             grow_o
);
  localparam logic [CNT_W:0] ONE_X = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + ONE_X;
  // the increase is due when this clean strobe completes the run
  assign grow_o  = (cmd_i == CMD_CLEAN) && (cnt_inc >= {1'b0, interval_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD:  cnt_q <= load_cnt_i;
        CMD_OVF:   cnt_q <= '0;
        CMD_CLEAN: cnt_q <= grow_o ? '0 : cnt_inc[CNT_W-1:0];
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  assert_count_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLEAN && !grow_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_OVF) |=> (cnt_q == '0));

  assert_count_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLEAN && grow_o) |=> (cnt_q == '0));
endmodule

// File: rtl/lsc_exp_reg.sv
module lsc_exp_reg
  import lsc_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int INIT_EXP = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  lsc_cmd_e                cmd_i,
  input  logic                    grow_i,
  input  logic signed [EXP_W-1:0] min_i,
  input  logic signed [EXP_W-1:0] max_i,
  input  logic signed [EXP_W-1:0] load_exp_i,
  output logic signed [EXP_W-1:0] exp_o
);
  localparam logic signed [EXP_W-1:0] RST_EXP = EXP_W'(INIT_EXP);
  localparam logic signed [EXP_W-1:0] ONE     = EXP_W'(1);

  logic signed [EXP_W-1:0] exp_q, exp_d;
  logic at_floor, at_ceil;

  assign at_floor = (exp_q <= min_i);
  assign at_ceil  = (exp_q >= max_i);

  always_comb begin
    exp_d = exp_q;
    unique case (cmd_i)
      CMD_LOAD:  exp_d = load_exp_i;
      CMD_OVF:   if (!at_floor) exp_d = exp_q - ONE;
      CMD_CLEAN: if (grow_i && !at_ceil) exp_d = exp_q + ONE;
      default:   exp_d = exp_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= RST_EXP;
    else         exp_q <= exp_d;
  end

  assign exp_o = exp_q;

  assert_halve_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_OVF && exp_q > min_i) |=> (exp_q == $past(exp_q) - ONE));

  assert_double_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLEAN && grow_i && exp_q < max_i) |=> (exp_q == $past(exp_q) + ONE));

  assert_floor_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_OVF && exp_q <= min_i) |=> $stable(exp_q));

  assert_ceil_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLEAN && exp_q >= max_i) |=> $stable(exp_q));

  assert_clean_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLEAN && !grow_i) |=> $stable(exp_q));
endmodule

// File: rtl/loss_scale_ctrl.sv
module loss_scale_ctrl
  import lsc_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int CNT_W    = 16,
  parameter int INIT_EXP = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    iter_valid_i,
  input  logic                    grad_overflow_i,
  input  logic [CNT_W-1:0]        cfg_interval_i,
  input  logic signed [EXP_W-1:0] cfg_min_exp_i,
  input  logic signed [EXP_W-1:0] cfg_max_exp_i,
  input  logic                    restore_i,
  input  logic signed [EXP_W-1:0] restore_exp_i,
  input  logic [CNT_W-1:0]        restore_cnt_i,
  output logic signed [EXP_W-1:0] scale_exp_o,
  output logic [CNT_W-1:0]        clean_cnt_o,
  output logic                    skip_o,
  output logic                    done_o
);
  lsc_cmd_e cmd;
  logic     grow;
  logic     skip_q, done_q;

  // restore wins over a strobe in the same cycle
  always_comb begin
    if (restore_i)                            cmd = CMD_LOAD;
    else if (iter_valid_i && grad_overflow_i) cmd = CMD_OVF;
    else if (iter_valid_i)                    cmd = CMD_CLEAN;
    else                                      cmd = CMD_IDLE;
  end

  lsc_clean_cnt #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .interval_i (cfg_interval_i),
    .load_cnt_i (restore_cnt_i),
    .cnt_o      (clean_cnt_o),
    .grow_o     (grow)
  );

  lsc_exp_reg #(
    .EXP_W    (EXP_W),
    .INIT_EXP (INIT_EXP)
  ) i_exp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .grow_i     (grow),
    .min_i      (cfg_min_exp_i),
    .max_i      (cfg_max_exp_i),
    .load_exp_i (restore_exp_i),
    .exp_o      (scale_exp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      skip_q <= (cmd == CMD_OVF);
      done_q <= (cmd == CMD_OVF) || (cmd == CMD_CLEAN);
    end
  end

  assign skip_o = skip_q;
  assign done_o = done_q;

  assert_skip_on_ovf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_valid_i && grad_overflow_i && !restore_i) |=> (skip_o && done_o));

  assert_restore_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (scale_exp_o == $past(restore_exp_i) &&
                   clean_cnt_o == $past(restore_cnt_i) && !done_o && !skip_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iter_valid_i || restore_i) |=> !done_o);

  assert_skip_needs_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> done_o);

  assert_clean_no_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_valid_i && !grad_overflow_i && !restore_i) |=> (done_o && !skip_o));
endmodule

// File: tb/test_loss_scale_ctrl.sv
module test_loss_scale_ctrl;
  localparam int EXP_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, ovf = 1'b0, ld = 1'b0;
  logic [CNT_W-1:0] interval = 16'd4;
  logic signed [EXP_W-1:0] min_e = -8'sd24, max_e = 8'sd30;
  logic signed [EXP_W-1:0] ld_exp = '0;
  logic [CNT_W-1:0] ld_cnt = '0;
  logic signed [EXP_W-1:0] exp_o;
  logic [CNT_W-1:0] cnt_o;
  logic skip_o, done_o;

  int errors = 0, checks = 0;
  int m_exp = 15, m_cnt = 0;
  bit m_skip = 0, m_done = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  loss_scale_ctrl #(.EXP_W(EXP_W), .CNT_W(CNT_W), .INIT_EXP(15)) i_loss_scale_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .iter_valid_i(stb), .grad_overflow_i(ovf),
    .cfg_interval_i(interval), .cfg_min_exp_i(min_e), .cfg_max_exp_i(max_e),
    .restore_i(ld), .restore_exp_i(ld_exp), .restore_cnt_i(ld_cnt),
    .scale_exp_o(exp_o), .clean_cnt_o(cnt_o), .skip_o(skip_o), .done_o(done_o));

  task automatic compare();
    checks++;
    if (int'(exp_o) != m_exp || int'(cnt_o) != m_cnt || skip_o != m_skip || done_o != m_done) begin
      errors++;
      $display("FAIL %s: exp=%0d cnt=%0d skip=%0b done=%0b expected exp=%0d cnt=%0d skip=%0b done=%0b",
               cur_req, exp_o, cnt_o, skip_o, done_o, m_exp, m_cnt, m_skip, m_done);
    end
  endtask

  // called at a falling edge: drive inputs, predict, step one clock, compare
  task automatic cycle(input bit s, input bit o, input bit l, input int le, input int lc);
    stb = s; ovf = o; ld = l;
    ld_exp = EXP_W'(le); ld_cnt = CNT_W'(lc);
    if (l) begin
      m_exp = le; m_cnt = lc; m_skip = 0; m_done = 0;
    end else if (s && o) begin
      if (m_exp > int'(min_e)) m_exp = m_exp - 1;
      m_cnt = 0; m_skip = 1; m_done = 1;
    end else if (s) begin
      if (m_cnt + 1 >= int'(interval)) begin
        if (m_exp < int'(max_e)) m_exp = m_exp + 1;
        m_cnt = 0;
      end else m_cnt = m_cnt + 1;
      m_skip = 0; m_done = 1;
    end else begin
      m_skip = 0; m_done = 0;
    end
    @(posedge clk);
    @(negedge clk);
    stb = 0; ovf = 0; ld = 0;
    compare();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R4: clean strobes below the interval only count
    cur_req = "R4";
    for (int i = 0; i < 3; i++) cycle(1, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    // R3: fourth clean strobe doubles
    cur_req = "R3";
    cycle(1, 0, 0, 0, 0);
    // R2: overflow halves and skips, count cleared
    cur_req = "R2";
    cycle(1, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    // R5: saturate at the minimum
    cur_req = "R5";
    min_e = 8'sd14;
    cycle(1, 1, 0, 0, 0);
    cycle(1, 1, 0, 0, 0);
    cycle(1, 1, 0, 0, 0);
    // R6: saturate at the maximum
    cur_req = "R6";
    max_e = 8'sd15;
    for (int i = 0; i < 8; i++) cycle(1, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0);
    // R7: restore beats a strobe in the same cycle
    cur_req = "R7";
    min_e = -8'sd10; max_e = 8'sd20;
    cycle(1, 1, 1, -5, 2);
    cycle(1, 0, 1, 7, 3);
    cycle(0, 0, 0, 0, 0);
    // R9: negative exponent visible and halving below zero
    cur_req = "R9";
    cycle(0, 0, 1, -3, 1);
    cycle(1, 1, 0, 0, 0);
    cycle(1, 1, 0, 0, 0);
    // R8: gaps between strobes give isolated pulses
    cur_req = "R8";
    for (int i = 0; i < 6; i++) begin
      cycle(1, i[0], 0, 0, 0);
      cycle(0, 0, 0, 0, 0);
      cycle(0, 0, 0, 0, 0);
    end
    // R3: default interval 2000, restored near the end of the run
    cur_req = "R3";
    interval = 16'd2000;
    cycle(0, 0, 1, 3, 1997);
    cycle(1, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0);
    // R4: long clean run at the default interval
    cur_req = "R4";
    for (int i = 0; i < 2100; i++) cycle(1, 0, 0, 0, 0);
    // R8: random mix in a narrow window
    cur_req = "R8";
    interval = 16'd3;
    min_e = -8'sd2; max_e = 8'sd2;
    cycle(0, 0, 1, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom_range(0, 15);
      automatic int le = $urandom_range(0, 4) - 2;
      cycle(r < 10, r[0], r == 15, le, r % 3);
    end
    finish_run();
  end
endmodule